// File: doc/BRIEF.md
# Period-Match Timer with Scalers

This block is an 8-bit up-counter with a programmable period. It advances on qualified pulses of a clock-enable input. A selectable prescaler divides those pulses by 1, 4, 16 or 64. The block compares the count with a period register on every clock cycle. While the two are equal and the timer is running, it drives a raw match output to downstream logic.

On the next prescaled tick the count goes back to zero, so a full cycle takes period+1 ticks. Each such tick is a match event. A postscaler counts match events and sets a sticky interrupt flag after a selectable number of them. Software clears the flag with a one-cycle strobe.

A small register port gives software read and write access to the count, the period and a control byte. The control byte holds the run bit, the postscale field and the prescale field. Writing the count or the control byte restarts both scalers from zero.

Top module: `pm_timer`

## Requirements
- R1: While running, each prescaled tick increments the count by one, unless the count equals the period on that tick.
- R2: Control bits [1:0] select the prescale. Values 0, 1, 2 and 3 give one tick per 1, 4, 16 and 64 cycles in which `tick_en` is high. Cycles with `tick_en` low neither advance nor age the prescaler.
- R3: `match_o` is high exactly when the run bit is set and the count equals the period. On the next prescaled tick the count becomes 00h, so one period lasts period+1 ticks.
- R4: With a period of 00h, every prescaled tick is a match event and the count stays at 00h.
- R5: Control bits [6:3] hold a postscale value N. `irq_o` sets on the (N+1)-th match event counted since the postscaler was last cleared.
- R6: While control bit 7 (run) is clear, the count holds its value, `match_o` stays low and `irq_o` does not set.
- R7: A write to the count (address 0) or to the control byte (address 2) clears both the prescaler and the postscaler. A write to the period (address 1) clears neither.
- R8: Synchronous reset sets the count to 00h, the period to FFh, the control byte to 00h and `irq_o` to 0.
- R9: `irq_o` stays set until a cycle with `irq_clr` high. If a match sets the flag in the same cycle as a clear, the flag stays set.
- R10: Address 0 reads and writes the count, address 1 the period and address 2 the control byte. Control bit 2 reads as 0 and address 3 reads 00h. A count write takes precedence over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count-rate qualifier fed to the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_clr | input | 1 | Strobe that clears the interrupt flag |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| match_o | output | 1 | Raw count-equals-period output |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench sweeps every prescale setting against several periods (including 00h) and postscale values, both with `tick_en` held high and with it pulsed every third cycle. After each cycle it checks the count, the match output and the flag against closed-form arithmetic.

Each sweep targets a specific mistake:
- A design that reloads at the moment of the match, rather than on the following tick, gets a period of P ticks instead of P+1.
- A design that counts matches off by one sets the flag one period early or one period late.
- A design that ages the prescaler while `tick_en` is low runs fast.

Directed sequences cover the scaler clears:
- A count write half-way through a prescale interval must push the next tick out by a full interval. A design that leaves the prescaler alone ticks early.
- A control rewrite between matches must discard a partial postscale count. A design that keeps it raises the flag early.
- A period write must not disturb tick timing.

Further sequences cover the remaining corner cases:
- Set beating clear on the flag.
- Count equal to the period while stopped, which must not raise the match output.
- A count write beating a tick in the same cycle.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    // Register port address width and the decode of each address.
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_COUNT  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_PERIOD = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd2;

endpackage

// File: rtl/pmt_prescale.sv
// Divides qualified pulses by 2**(STEP*sel); sel = 0 passes every pulse.
module pmt_prescale #(
    parameter int SEL_W = 2,
    parameter int STEP  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int NSEL = 1 << SEL_W;
    localparam int RAW  = STEP * (NSEL - 1);
    localparam int PCW  = (RAW > 0) ? RAW : 1;

    typedef struct packed {
        logic [PCW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;

    // Terminal count for each selection, computed rather than tabulated.
    logic [PCW-1:0] term [NSEL];

    for (genvar i = 0; i < NSEL; i++) begin : g_term
        assign term[i] = PCW'((1 << (i * STEP)) - 1);
    end

    always_comb begin
        s_d  = s_q;
        tick = adv && (s_q.cnt == term[sel]);

        if (clr) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = '0;
        end else if (adv) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pmt_postscale.sv
// Counts match events; fires on the event that brings the count past sel.
module pmt_postscale #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         evt,
    input  logic [W-1:0] sel,
    output logic         fire
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } post_state_t;

    post_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        fire = 1'b0;

        if (clr) begin
            s_d.cnt = '0;
        end else if (evt) begin
            if (s_q.cnt == sel) begin
                fire    = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pm_timer.sv
// Period-match timer: counter, period compare, prescaler, postscaler and
// a sticky interrupt flag, with a small register port.
// Control byte: [CTRL_W-1] run, [PRE_SEL_W+1 +: POST_W] postscale,
// [PRE_SEL_W] reads zero, [PRE_SEL_W-1:0] prescale. CTRL_W must not exceed CNT_W.
module pm_timer #(
    parameter int CNT_W     = 8,
    parameter int PRE_SEL_W = 2,
    parameter int PRE_STEP  = 2,
    parameter int POST_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick_en,
    input  logic                      wr_en,
    input  logic [pmt_pkg::ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]          wr_data,
    input  logic                      irq_clr,
    input  logic [pmt_pkg::ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]          rd_data,
    output logic                      match_o,
    output logic                      irq_o
);

    import pmt_pkg::*;

    localparam int CTRL_W  = PRE_SEL_W + POST_W + 2;
    localparam int RUN_BIT = CTRL_W - 1;
    localparam int POST_LO = PRE_SEL_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     per;
        logic                 run;
        logic [POST_W-1:0]    post;
        logic [PRE_SEL_W-1:0] pre;
        logic                 irq;
    } tmr_state_t;

    tmr_state_t s_d, s_q;

    logic cnt_wr, per_wr, ctl_wr;
    logic scaler_clr;
    logic tick;
    logic match_evt;
    logic fire;

    // Names brought out for the bound checker.
    logic [CNT_W-1:0] cnt_q, per_q;
    logic             run_q;

    assign cnt_q = s_q.cnt;
    assign per_q = s_q.per;
    assign run_q = s_q.run;

    assign cnt_wr     = wr_en && (wr_addr == ADR_COUNT);
    assign per_wr     = wr_en && (wr_addr == ADR_PERIOD);
    assign ctl_wr     = wr_en && (wr_addr == ADR_CTRL);
    assign scaler_clr = cnt_wr || ctl_wr;

    pmt_prescale #(
        .SEL_W (PRE_SEL_W),
        .STEP  (PRE_STEP)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (scaler_clr),
        .adv  (tick_en && s_q.run),
        .sel  (s_q.pre),
        .tick (tick)
    );

    pmt_postscale #(
        .W (POST_W)
    ) u_post (
        .clk  (clk),
        .rst  (rst),
        .clr  (scaler_clr),
        .evt  (match_evt),
        .sel  (s_q.post),
        .fire (fire)
    );

    always_comb begin
        s_d       = s_q;
        match_evt = tick && (s_q.cnt == s_q.per);

        // Count: a software write wins over a tick in the same cycle.
        if (cnt_wr) begin
            s_d.cnt = wr_data;
        end else if (tick) begin
            s_d.cnt = match_evt ? '0 : s_q.cnt + 1'b1;
        end

        if (per_wr) begin
            s_d.per = wr_data;
        end

        if (ctl_wr) begin
            s_d.run  = wr_data[RUN_BIT];
            s_d.post = wr_data[POST_LO +: POST_W];
            s_d.pre  = wr_data[PRE_SEL_W-1:0];
        end

        // Sticky flag: set takes priority over clear.
        if (fire) begin
            s_d.irq = 1'b1;
        end else if (irq_clr) begin
            s_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cnt  <= '0;
            s_q.per  <= '1;
            s_q.run  <= 1'b0;
            s_q.post <= '0;
            s_q.pre  <= '0;
            s_q.irq  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // Register read port.
    logic [CNT_W-1:0] ctrl_rd;

    always_comb begin
        ctrl_rd                       = '0;
        ctrl_rd[RUN_BIT]              = s_q.run;
        ctrl_rd[POST_LO +: POST_W]    = s_q.post;
        ctrl_rd[PRE_SEL_W-1:0]        = s_q.pre;

        case (rd_addr)
            ADR_COUNT:  rd_data = s_q.cnt;
            ADR_PERIOD: rd_data = s_q.per;
            ADR_CTRL:   rd_data = ctrl_rd;
            default:    rd_data = '0;
        endcase
    end

    assign match_o = s_q.run && (s_q.cnt == s_q.per);
    assign irq_o   = s_q.irq;

endmodule

// File: rtl/pm_timer_chk.sv
module pm_timer_chk #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq_clr,
    input logic              match_o,
    input logic              irq_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  per_q,
    input logic              run_q,
    input logic              tick,
    input logic              match_evt,
    input logic              fire
);

    logic cnt_wr_c;

    assign cnt_wr_c = wr_en && (wr_addr == pmt_pkg::ADR_COUNT);

    assert_reset_vals_R8: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && per_q == '1 && !irq_o));

    assert_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !match_evt && !cnt_wr_c) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    assert_tick_gate_R2: assert property (@(posedge clk) disable iff (rst)
        tick |-> (run_q && tick_en));

    assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (match_evt && !cnt_wr_c) |=> (cnt_q == '0));

    assert_flag_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(fire));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cnt_wr_c) |=> $stable(cnt_q));

    assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> !match_o);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !irq_clr) |=> irq_o);

endmodule

bind pm_timer pm_timer_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (pmt_pkg::ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .irq_clr   (irq_clr),
    .match_o   (match_o),
    .irq_o     (irq_o),
    .cnt_q     (cnt_q),
    .per_q     (per_q),
    .run_q     (run_q),
    .tick      (tick),
    .match_evt (match_evt),
    .fire      (fire)
);

// File: tb/sim_pm_timer.sv
`timescale 1ns/1ps
module sim_pm_timer;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_en;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       irq_clr;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic       match_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pm_timer u0 (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .irq_clr (irq_clr),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .match_o (match_o),
        .irq_o   (irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic c);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        irq_clr = c;
        step();
        wr_en   = 1'b0;
        irq_clr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
        rd_addr = 2'd0;
    endtask

    function automatic logic [7:0] mk(input logic run, input logic [3:0] post, input logic [1:0] pre);
        return {run, post, 1'b0, pre};
    endfunction

    // Sweep: tick_en high every G-th cycle, prescale p, period P, postscale N.
    task automatic sweep(input int g, input int p, input int per, input int n);
        int d;
        int k_max;
        int v;
        string tag;
        d = 1 << (2 * p);
        k_max = d * g * (per + 1) * (n + 2) + 2;
        tag = $sformatf("g=%0d p=%0d P=%0d N=%0d", g, p, per, n);
        wr(2'd1, 8'(per), 1'b0);
        wr(2'd2, mk(1'b0, 4'(n), 2'(p)), 1'b0);
        wr(2'd0, 8'd0, 1'b1);
        wr(2'd2, mk(1'b1, 4'(n), 2'(p)), 1'b0);
        for (int k = 0; k <= k_max; k++) begin
            int pulses;
            int t;
            pulses = k / g;
            t = pulses / d;
            rd(2'd0, v);
            if (per == 0) begin
                chk({"R4 count ", tag}, v, 0);
            end else begin
                chk({"R1/R2 count ", tag}, v, t % (per + 1));
            end
            chk({"R3 match ", tag}, int'(match_o), ((t % (per + 1)) == per) ? 1 : 0);
            chk({"R5 irq ", tag}, int'(irq_o), ((t / (per + 1)) >= n + 1) ? 1 : 0);
            tick_en = (((k + 1) % g) == 0);
            step();
        end
        tick_en = 1'b1;
        wr(2'd2, 8'd0, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int c;
        rst = 1'b1;
        tick_en = 1'b1;
        wr_en = 1'b0;
        wr_addr = 2'd0;
        wr_data = 8'd0;
        irq_clr = 1'b0;
        rd_addr = 2'd0;
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;

        // R8: reset state
        rd(2'd0, v); chk("R8 count after reset", v, 0);
        rd(2'd1, v); chk("R8 period after reset", v, 255);
        rd(2'd2, v); chk("R8 control after reset", v, 0);
        chk("R8 irq after reset", int'(irq_o), 0);
        chk("R8 match after reset", int'(match_o), 0);

        // R10: register map
        wr(2'd1, 8'h5A, 1'b0);
        rd(2'd1, v); chk("R10 period readback", v, 8'h5A);
        wr(2'd2, 8'hFF, 1'b0);
        rd(2'd2, v); chk("R10 control readback bit2 zero", v, 8'hFB);
        wr(2'd2, 8'h00, 1'b0);
        rd(2'd3, v); chk("R10 address 3 reads zero", v, 0);
        wr(2'd0, 8'h33, 1'b0);
        rd(2'd0, v); chk("R10 count readback", v, 8'h33);

        // R10: count write beats a tick
        wr(2'd1, 8'hFF, 1'b0);
        wr(2'd0, 8'h00, 1'b0);
        wr(2'd2, mk(1'b1, 4'd0, 2'd0), 1'b0);
        repeat (3) step();
        rd(2'd0, v); chk("R1 free-run count", v, 3);
        wr(2'd0, 8'h40, 1'b0);
        rd(2'd0, v); chk("R10 count write precedence", v, 8'h40);
        step();
        rd(2'd0, v); chk("R1 count after write", v, 8'h41);

        // R6: stopped timer holds and stays quiet
        wr(2'd2, mk(1'b0, 4'd0, 2'd0), 1'b0);
        rd(2'd0, c);
        repeat (10) step();
        rd(2'd0, v); chk("R6 count holds while stopped", v, c);
        wr(2'd1, 8'h00, 1'b0);
        wr(2'd0, 8'h00, 1'b1);
        repeat (5) step();
        chk("R6 no match while stopped", int'(match_o), 0);
        chk("R6 no irq while stopped", int'(irq_o), 0);

        // R9: set beats clear, clear works, flag is sticky
        wr(2'd2, mk(1'b1, 4'd0, 2'd0), 1'b0);
        chk("R9 irq not yet set", int'(irq_o), 0);
        step();
        chk("R9 irq set by match", int'(irq_o), 1);
        irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        chk("R9 set wins over clear", int'(irq_o), 1);
        wr(2'd2, mk(1'b0, 4'd0, 2'd0), 1'b1);
        chk("R9 clear strobe", int'(irq_o), 0);
        repeat (3) step();
        chk("R9 stays clear", int'(irq_o), 0);
        wr(2'd2, mk(1'b1, 4'd0, 2'd0), 1'b0);
        step();
        wr(2'd2, mk(1'b0, 4'd0, 2'd0), 1'b0);
        repeat (5) step();
        chk("R9 sticky while stopped", int'(irq_o), 1);

        // R7: count write clears the prescaler
        wr(2'd1, 8'hFF, 1'b0);
        wr(2'd2, mk(1'b0, 4'd0, 2'd1), 1'b0);
        wr(2'd0, 8'd0, 1'b1);
        wr(2'd2, mk(1'b1, 4'd0, 2'd1), 1'b0);
        step();
        wr(2'd0, 8'd5, 1'b0);
        repeat (3) step();
        rd(2'd0, v); chk("R7 prescaler cleared by count write", v, 5);
        step();
        rd(2'd0, v); chk("R7 tick after full interval", v, 6);

        // R7: period write leaves the prescaler alone
        wr(2'd2, mk(1'b0, 4'd0, 2'd1), 1'b0);
        wr(2'd0, 8'd0, 1'b0);
        wr(2'd2, mk(1'b1, 4'd0, 2'd1), 1'b0);
        step();
        wr(2'd1, 8'hFF, 1'b0);
        step();
        rd(2'd0, v); chk("R7 period write no tick yet", v, 0);
        step();
        rd(2'd0, v); chk("R7 period write keeps tick timing", v, 1);

        // R7: control write clears the postscaler
        wr(2'd2, mk(1'b0, 4'd1, 2'd0), 1'b0);
        wr(2'd1, 8'd0, 1'b0);
        wr(2'd0, 8'd0, 1'b1);
        wr(2'd2, mk(1'b1, 4'd1, 2'd0), 1'b0);
        step();
        chk("R5 one match below postscale", int'(irq_o), 0);
        wr(2'd2, mk(1'b1, 4'd1, 2'd0), 1'b0);
        chk("R7 postscaler cleared by control write", int'(irq_o), 0);
        step();
        chk("R7 partial count discarded", int'(irq_o), 0);
        step();
        chk("R5 irq after two fresh matches", int'(irq_o), 1);
        wr(2'd2, 8'd0, 1'b1);

        // Sweeps for R1..R5
        for (int g = 1; g <= 3; g += 2) begin
            for (int p = 0; p < 4; p++) begin
                sweep(g, p, 0, 0);
                sweep(g, p, 2, 3);
                sweep(g, p, 5, 0);
                sweep(g, p, 2, 0);
                sweep(g, p, 0, 3);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule